// File: doc/BRIEF.md
# RS-485 Automatic Driver-Enable Controller

This block owns the driver-enable (RTS) line of a UART that talks over a half-duplex RS-485 pair. A single configuration word selects whether the automatic mode is on and whether its result reaches the RTS pin, with which polarity, and how many bit times the driver stays on after the last character has left the wire. While the transmitter is busy or has characters queued, the driver is enabled. Once everything has drained, the block counts bit-time ticks from the baud generator and then turns the driver off. New data arriving during that countdown keeps the driver on and cancels the countdown.

When automatic mode is off, or its output is not routed to the pin, the pin simply mirrors the ordinary modem-control RTS bit supplied by software. When automatic mode owns the pin, that software bit has no effect. There is no programmable lead time before transmission starts. The driver turns on in the same cycle that work appears.

Top module: `rs485_dir_ctl`

## Requirements
- R1: A pulse on `cfg_we` loads `cfg_wdata` into the configuration word at the clock edge, and the new value takes effect from the next cycle. The field layout is: bit 0 turns automatic mode on, bit 1 routes it to the pin, bit 2 inverts the pin level, and bits 11:8 hold the post-transmit delay D (0 to 15). After reset the word is zero.
- R2: When bit 0 or bit 1 is clear, `rts_pin` equals `modem_rts` in the same cycle.
- R3: When bits 0 and 1 are both set, changes of `modem_rts` do not change `rts_pin`.
- R4: With automatic mode on, `de_active` is 1 in the same cycle in which work is pending, meaning `tx_busy` is 1 or `tx_empty` is 0.
- R5: When the pin is owned, `rts_pin` equals `de_active` if bit 2 is 0, and equals its inverse if bit 2 is 1.
- R6: After a drain, meaning no work is pending, `de_active` stays 1 until D+1 `bit_tick` pulses have been seen in drained cycles. It falls in the cycle after the tick that completes that count.
- R7: With D = 0, `de_active` falls in the cycle after the first drained-cycle tick.
- R8: Work that becomes pending during the countdown keeps `de_active` at 1 and discards the ticks counted so far. The next drain needs a full D+1 ticks again.
- R9: With bit 0 clear, `de_active` is 0 and any countdown in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| modem_rts | input | 1 | Software modem-control RTS bit |
| tx_busy | input | 1 | Transmit shift register is sending |
| tx_empty | input | 1 | Transmit holding FIFO is empty |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| de_active | output | 1 | Logical driver-enable state |
| rts_pin | output | 1 | RTS pin level |

## Verification
The assertions assume that `bit_tick` is a single-cycle strobe and that the transmitter flags are synchronous to `clk`. They make no assumption about how `tx_busy` and `tx_empty` relate to each other, so any combination is legal. The random stimulus drives both flags and the tick independently from a fixed seed. It also rewrites the configuration at random moments, including during a countdown, and stays within these assumptions because every input changes only on the inactive clock edge. Directed sequences place ticks exactly at the boundary of D+1 drained ticks for delays 0 and 3, and insert new work in the middle of a countdown.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  localparam int CFG_W   = 16;
  localparam int DLY_W   = 4;
  localparam int BIT_EN  = 0;
  localparam int BIT_OWN = 1;
  localparam int BIT_INV = 2;
  localparam int DLY_LSB = 8;

  typedef struct packed {
    logic             auto_on;
    logic             route_pin;
    logic             invert;
    logic [DLY_W-1:0] delay;
  } dir_cfg_t;

  function automatic dir_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    dir_cfg_t c;
    c.auto_on   = w[BIT_EN];
    c.route_pin = w[BIT_OWN];
    c.invert    = w[BIT_INV];
    c.delay     = w[DLY_LSB +: DLY_W];
    return c;
  endfunction

  // Ticks already counted plus the current one exceed the delay -> release.
  function automatic logic release_due(input logic [DLY_W-1:0] seen,
                                       input logic [DLY_W-1:0] dly);
    return ({1'b0, seen} + 1'b1) > {1'b0, dly};
  endfunction

  function automatic logic pin_level(input logic de, input logic inv);
    return de ^ inv;
  endfunction
endpackage

// File: rtl/rs485_cfg_reg.sv
module rs485_cfg_reg
  import rs485_dir_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output dir_cfg_t     cfg
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= '0;
    else if (we) word_q <= wdata;
  end

  assign cfg = unpack_cfg(word_q);

  // R1: the stored word changes only at a write strobe
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(word_q));
endmodule

// File: rtl/rs485_turnaround.sv
module rs485_turnaround
  import rs485_dir_pkg::*;
#(
  parameter int DW = DLY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_on,
  input  logic [DW-1:0] delay,
  input  logic          pending,
  input  logic          tick,
  output logic          de
);
  typedef enum logic {ST_IDLE, ST_ARMED} dir_st_t;

  dir_st_t       st_q;
  logic [DW-1:0] seen_q;
  logic          drained_tick;
  logic          release_now;
  logic          armed;

  assign armed        = (st_q == ST_ARMED);
  assign drained_tick = armed && !pending && tick;
  assign release_now  = drained_tick && release_due(seen_q, delay);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      seen_q <= '0;
    end else if (!auto_on) begin
      st_q   <= ST_IDLE;
      seen_q <= '0;
    end else if (pending) begin
      st_q   <= ST_ARMED;
      seen_q <= '0;
    end else if (release_now) begin
      st_q   <= ST_IDLE;
      seen_q <= '0;
    end else if (drained_tick) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  assign de = auto_on && (armed || pending);

  // R4: pending work arms the controller for the next cycle
  p_pending_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && pending) |=> armed);
  // R6: a drained cycle without a tick keeps the count and the arming
  p_no_tick_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && armed && !pending && !tick) |=> (armed && $stable(seen_q)));
  // R6: arming only ends on a tick or on disable
  p_release_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> ($past(tick) || !$past(auto_on)));
  // R9: disabled mode abandons any countdown
  p_disable_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_on |=> (!armed && seen_q == '0));
endmodule

// File: rtl/rs485_pin_mux.sv
module rs485_pin_mux
  import rs485_dir_pkg::*;
(
  input  logic owned,
  input  logic invert,
  input  logic de,
  input  logic modem_rts,
  output logic pin
);
  always_comb begin
    if (owned) pin = pin_level(de, invert);
    else       pin = modem_rts;
  end
endmodule

// File: rtl/rs485_dir_ctl.sv
module rs485_dir_ctl
  import rs485_dir_pkg::*;
#(
  parameter int CW = CFG_W,
  parameter int DW = DLY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          modem_rts,
  input  logic          tx_busy,
  input  logic          tx_empty,
  input  logic          bit_tick,
  output logic          de_active,
  output logic          rts_pin
);
  dir_cfg_t cfg;
  logic     pending;
  logic     owned;

  assign pending = tx_busy || !tx_empty;
  assign owned   = cfg.auto_on && cfg.route_pin;

  rs485_cfg_reg #(.W(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );

  rs485_turnaround #(.DW(DW)) u_turn (
    .clk(clk), .rst_n(rst_n), .auto_on(cfg.auto_on), .delay(cfg.delay),
    .pending(pending), .tick(bit_tick), .de(de_active)
  );

  rs485_pin_mux u_mux (
    .owned(owned), .invert(cfg.invert), .de(de_active),
    .modem_rts(modem_rts), .pin(rts_pin)
  );

  // R3: with the pin owned, the pin moves only with the enable state or polarity
  p_owned_ignores_modem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && $past(owned) && $stable(de_active) && $stable(cfg.invert))
      |-> $stable(rts_pin));
  // R9: automatic mode off means no driver enable
  p_off_no_de_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.auto_on |-> !de_active);
endmodule

// File: tb/rs485_dir_ctl_tb_top.sv
`timescale 1ns/1ps
module rs485_dir_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        modem_rts = 1'b0;
  logic        tx_busy = 1'b0;
  logic        tx_empty = 1'b1;
  logic        bit_tick = 1'b0;
  logic        de_active, rts_pin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] m_cfg = '0;
  bit          m_armed = 1'b0;
  int          m_ticks = 0;

  always #2.5 clk = ~clk;

  rs485_dir_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .modem_rts(modem_rts), .tx_busy(tx_busy), .tx_empty(tx_empty),
    .bit_tick(bit_tick), .de_active(de_active), .rts_pin(rts_pin)
  );

  function automatic bit exp_de();
    bit work = tx_busy || !tx_empty;
    return m_cfg[0] && (m_armed || work);
  endfunction

  function automatic bit exp_pin();
    if (m_cfg[0] && m_cfg[1]) return exp_de() ? !m_cfg[2] : m_cfg[2];
    return modem_rts;
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare, then advance model at posedge
  task automatic cyc(input bit busy, input bit empty, input bit tk, input bit mrts,
                     input bit we, input logic [15:0] wd, input string tag);
    @(negedge clk);
    tx_busy = busy; tx_empty = empty; bit_tick = tk; modem_rts = mrts;
    cfg_we = we; cfg_wdata = wd;
    #1;
    check({tag, " de"}, de_active, exp_de());
    check({tag, " pin"}, rts_pin, exp_pin());
    @(posedge clk);
    if (!m_cfg[0]) begin
      m_armed = 0; m_ticks = 0;
    end else if (busy || !empty) begin
      m_armed = 1; m_ticks = 0;
    end else if (m_armed && tk) begin
      m_ticks++;
      if (m_ticks > int'(m_cfg[11:8])) begin m_armed = 0; m_ticks = 0; end
    end
    if (we) m_cfg = wd;
  endtask

  task automatic idle(input int n, input bit tk, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 1, tk, modem_rts, 0, 16'h0, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0485));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // reset state: word zero, pin mirrors modem bit (R1, R2)
    #1; check("R1 reset de", de_active, 1'b0);
    modem_rts = 1'b1; #0.5; check("R2 reset pin", rts_pin, 1'b1);
    cyc(1, 0, 0, 1, 0, 0, "R2 off follows modem");
    cyc(1, 0, 0, 0, 0, 0, "R2 off follows modem low");

    // enable without pin routing: pin still follows modem (R2)
    cyc(0, 1, 0, 0, 1, 16'h0301, "R1 write en only");
    cyc(1, 0, 0, 1, 0, 0, "R2 en no route");
    cyc(0, 1, 0, 1, 0, 0, "R4 de without route");

    // own pin, delay 3, active high
    idle(6, 1, "R6 flush");
    cyc(0, 1, 0, 0, 1, 16'h0303, "R1 write owned d3");
    // modem toggles ignored (R3)
    cyc(0, 1, 0, 1, 0, 0, "R3 modem high ignored");
    check("R3 pin low idle", rts_pin, 1'b0);
    cyc(0, 1, 0, 0, 0, 0, "R3 modem low ignored");
    // same-cycle assertion (R4)
    cyc(0, 0, 0, 0, 0, 0, "R4 fifo nonempty");
    check("R4 de same cycle", de_active, 1'b1);
    cyc(1, 1, 1, 0, 0, 0, "R4 busy tick ignored");
    // drain: 3 ticks keep, 4th releases next cycle (R6)
    cyc(0, 1, 1, 0, 0, 0, "R6 tick1");
    cyc(0, 1, 0, 0, 0, 0, "R6 gap");
    cyc(0, 1, 1, 0, 0, 0, "R6 tick2");
    cyc(0, 1, 1, 0, 0, 0, "R6 tick3");
    cyc(0, 1, 1, 0, 0, 0, "R6 tick4");
    check("R6 held through tick4 cycle", de_active, 1'b1);
    cyc(0, 1, 0, 0, 0, 0, "R6 released");
    check("R6 low after tick4", de_active, 1'b0);

    // cancel (R8)
    cyc(1, 1, 0, 0, 0, 0, "R8 start");
    cyc(0, 1, 1, 0, 0, 0, "R8 t1");
    cyc(0, 1, 1, 0, 0, 0, "R8 t2");
    cyc(0, 0, 1, 0, 0, 0, "R8 new data");
    check("R8 kept", de_active, 1'b1);
    cyc(0, 1, 1, 0, 0, 0, "R8 r1");
    cyc(0, 1, 1, 0, 0, 0, "R8 r2");
    cyc(0, 1, 1, 0, 0, 0, "R8 r3");
    check("R8 still on after 3", de_active, 1'b1);
    cyc(0, 1, 1, 0, 0, 0, "R8 r4");
    cyc(0, 1, 0, 0, 0, 0, "R8 done");
    check("R8 off after full count", de_active, 1'b0);

    // polarity inverted, delay 0 (R5, R7)
    cyc(0, 1, 0, 0, 1, 16'h0007, "R1 write inv d0");
    cyc(0, 1, 0, 0, 0, 0, "R5 idle inverted");
    check("R5 idle pin high", rts_pin, 1'b1);
    cyc(1, 1, 0, 0, 0, 0, "R5 active inverted");
    check("R5 active pin low", rts_pin, 1'b0);
    cyc(0, 1, 0, 0, 0, 0, "R7 drained no tick");
    cyc(0, 1, 1, 0, 0, 0, "R7 first tick");
    check("R7 on during tick", de_active, 1'b1);
    cyc(0, 1, 0, 0, 0, 0, "R7 released");
    check("R7 off", de_active, 1'b0);

    // disable mid countdown (R9)
    cyc(0, 1, 0, 0, 1, 16'h0F03, "R1 write d15");
    cyc(1, 0, 0, 0, 0, 0, "R9 arm");
    cyc(0, 1, 1, 1, 1, 16'h0F02, "R9 disable");
    cyc(0, 1, 0, 1, 0, 0, "R9 off");
    check("R9 de low", de_active, 1'b0);
    check("R9 pin = modem", rts_pin, 1'b1);
    cyc(0, 1, 0, 0, 1, 16'h0F03, "R9 re-enable");
    cyc(0, 1, 0, 0, 0, 0, "R9 countdown gone");
    check("R9 no stale arm", de_active, 1'b0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit we = ($urandom_range(0, 39) == 0);
      logic [15:0] wd = {4'h0, 4'($urandom), 5'h0, 3'($urandom)};
      bit burst = ($urandom_range(0, 9) < 3);
      cyc(burst && $urandom_range(0, 1), !(burst && $urandom_range(0, 1)),
          ($urandom_range(0, 3) == 0), $urandom_range(0, 1), we, wd,
          "R6 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule